// File: doc/BRIEF.md
# Register-Set Branch Classifier

The block receives one decoded instruction record per clock from a trace front end and sorts it into one of eight classes: a non-branch or one of seven control-flow kinds. It never looks at an opcode. The decision rests only on which architectural registers the record names as sources and destinations: the stack pointer, the flags register, the instruction pointer, and any other register.

Each record has a valid strobe, a fixed number of destination register slots, a fixed number of source register slots, and the taken bit the trace recorded. A slot that holds ID 0 is empty. The result is registered and appears one clock after the record. It has a valid flag, a 3-bit class code, an is-branch flag and a final taken bit. Downstream predictor-training and statistics logic use this result.

Top module: `brc_classify_top`

## Requirements
- R1: Register ID 0 in any slot is ignored. A record whose slots are all zero is classified as not-branch (code 0) with taken 0.
- R2: The class codes are: 0 not-branch, 1 direct jump, 2 indirect jump, 3 conditional, 4 direct call, 5 indirect call, 6 return, 7 other. The six rules below are tested in the order of R3 to R7, and the first rule that matches wins.
- R3: Direct jump (code 1): the record writes ip and reads none of sp, flags or any other register. Indirect jump (code 2): the record writes ip, reads some other register, and reads none of sp, ip or flags.
- R4: Conditional (code 3): the record reads ip and writes ip, reads flags or some other register, and neither reads nor writes sp.
- R5: Direct call (code 4): the record reads sp and ip, writes sp and ip, and reads neither flags nor any other register. Indirect call (code 5) is the same, except that it reads some other register.
- R6: Return (code 6): the record reads sp, does not read ip, and writes sp and ip.
- R7: A record that writes ip but matches no earlier rule is other (code 7). A record that does not write ip is not-branch (code 0).
- R8: For conditional and other, taken_o copies in_taken_i. For codes 1, 2, 4, 5 and 6, taken_o is 1. For not-branch, taken_o is 0. is_branch_o is 0 exactly when the code is 0.
- R9: Every output has a latency of one clock: out_valid_o equals the in_valid_i of the previous cycle. Reset clears out_valid_o.
- R10: The sp, flags and ip IDs are parameters. Their defaults are 6, 25 and 26. A "reads other" source is any nonzero source ID that differs from all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input record valid |
| in_dst_i | input | N_DST*8 | Destination register IDs; slot k is at bits [8k+7:8k] |
| in_src_i | input | N_SRC*8 | Source register IDs; slot k is at bits [8k+7:8k] |
| in_taken_i | input | 1 | Taken bit from the trace |
| out_valid_o | output | 1 | Result valid |
| out_type_o | output | 3 | Class code |
| is_branch_o | output | 1 | Record is a branch |
| taken_o | output | 1 | Final taken bit |

## Verification
The checker assumes that the three special register IDs are nonzero and distinct. It also assumes that the inputs are stable at each rising clock edge. The stimulus draws register IDs mostly from the three special IDs, zero and a handful of ordinary IDs, so every combination of read and write flags comes up often, including records that name a special ID twice. Directed records cover each class, the all-zero record, and a record that writes ip while reading ip, flags and sp. The last one must land in other. Random records then run with in_valid_i toggling, and a behavioural model in the bench checks them every clock.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [2:0] {
    BT_NONE     = 3'd0,
    BT_JMP      = 3'd1,
    BT_JMP_IND  = 3'd2,
    BT_COND     = 3'd3,
    BT_CALL     = 3'd4,
    BT_CALL_IND = 3'd5,
    BT_RET      = 3'd6,
    BT_OTHER    = 3'd7
  } br_kind_e;

  typedef struct packed {
    logic wr_sp;
    logic wr_ip;
    logic rd_sp;
    logic rd_fl;
    logic rd_ip;
    logic rd_ot;
  } reg_use_t;
endpackage

// File: rtl/brc_slot_scan.sv
module brc_slot_scan #(
  parameter int unsigned N_SLOT = 4,
  parameter int unsigned ID_W   = 8,
  parameter logic [7:0]  SP_ID  = 8'd6,
  parameter logic [7:0]  FL_ID  = 8'd25,
  parameter logic [7:0]  IP_ID  = 8'd26
) (
  input  logic [N_SLOT*ID_W-1:0] ids_i,
  output logic                   hit_sp_o,
  output logic                   hit_fl_o,
  output logic                   hit_ip_o,
  output logic                   hit_ot_o
);
  logic [N_SLOT-1:0] sp_v, fl_v, ip_v, ot_v;

  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    logic [ID_W-1:0] id;
    assign id      = ids_i[k*ID_W +: ID_W];
    assign sp_v[k] = (id == ID_W'(SP_ID));
    assign fl_v[k] = (id == ID_W'(FL_ID));
    assign ip_v[k] = (id == ID_W'(IP_ID));
    // empty slot (0) never counts
    assign ot_v[k] = (id != '0) && !sp_v[k] && !fl_v[k] && !ip_v[k];
  end

  assign hit_sp_o = |sp_v;
  assign hit_fl_o = |fl_v;
  assign hit_ip_o = |ip_v;
  assign hit_ot_o = |ot_v;
endmodule

// File: rtl/brc_rules.sv
module brc_rules
  import brc_pkg::*;
(
  input  reg_use_t u_i,
  input  logic     taken_i,
  output br_kind_e kind_o,
  output logic     taken_o
);
  always_comb begin
    kind_o  = BT_NONE;
    taken_o = 1'b0;
    if (!u_i.rd_sp && !u_i.rd_fl && u_i.wr_ip && !u_i.rd_ot) begin
      kind_o  = BT_JMP;
      taken_o = 1'b1;
    end else if (!u_i.rd_sp && !u_i.rd_ip && !u_i.rd_fl && u_i.wr_ip && u_i.rd_ot) begin
      kind_o  = BT_JMP_IND;
      taken_o = 1'b1;
    end else if (!u_i.rd_sp && u_i.rd_ip && !u_i.wr_sp && u_i.wr_ip &&
                 (u_i.rd_fl || u_i.rd_ot)) begin
      kind_o  = BT_COND;
      taken_o = taken_i;
    end else if (u_i.rd_sp && u_i.rd_ip && u_i.wr_sp && u_i.wr_ip &&
                 !u_i.rd_fl && !u_i.rd_ot) begin
      kind_o  = BT_CALL;
      taken_o = 1'b1;
    end else if (u_i.rd_sp && u_i.rd_ip && u_i.wr_sp && u_i.wr_ip &&
                 !u_i.rd_fl && u_i.rd_ot) begin
      kind_o  = BT_CALL_IND;
      taken_o = 1'b1;
    end else if (u_i.rd_sp && !u_i.rd_ip && u_i.wr_sp && u_i.wr_ip) begin
      kind_o  = BT_RET;
      taken_o = 1'b1;
    end else if (u_i.wr_ip) begin
      kind_o  = BT_OTHER;
      taken_o = taken_i;
    end
  end
endmodule

// File: rtl/brc_classify_top.sv
module brc_classify_top
  import brc_pkg::*;
#(
  parameter int unsigned N_DST = 2,
  parameter int unsigned N_SRC = 4,
  parameter logic [7:0]  SP_ID = 8'd6,
  parameter logic [7:0]  FL_ID = 8'd25,
  parameter logic [7:0]  IP_ID = 8'd26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [N_DST*8-1:0] in_dst_i,
  input  logic [N_SRC*8-1:0] in_src_i,
  input  logic             in_taken_i,
  output logic             out_valid_o,
  output logic [2:0]       out_type_o,
  output logic             is_branch_o,
  output logic             taken_o
);
  localparam int unsigned ID_W = 8;

  reg_use_t use_w;
  br_kind_e kind_w;
  logic     tk_w;
  logic     d_sp, d_fl, d_ip, d_ot;
  logic     s_sp, s_fl, s_ip, s_ot;

  brc_slot_scan #(.N_SLOT(N_DST), .ID_W(ID_W), .SP_ID(SP_ID), .FL_ID(FL_ID), .IP_ID(IP_ID))
    u_dst (.ids_i(in_dst_i), .hit_sp_o(d_sp), .hit_fl_o(d_fl), .hit_ip_o(d_ip), .hit_ot_o(d_ot));

  brc_slot_scan #(.N_SLOT(N_SRC), .ID_W(ID_W), .SP_ID(SP_ID), .FL_ID(FL_ID), .IP_ID(IP_ID))
    u_src (.ids_i(in_src_i), .hit_sp_o(s_sp), .hit_fl_o(s_fl), .hit_ip_o(s_ip), .hit_ot_o(s_ot));

  always_comb begin
    use_w.wr_sp = d_sp;
    use_w.wr_ip = d_ip;
    use_w.rd_sp = s_sp;
    use_w.rd_fl = s_fl;
    use_w.rd_ip = s_ip;
    use_w.rd_ot = s_ot;
  end

  brc_rules u_rules (.u_i(use_w), .taken_i(in_taken_i), .kind_o(kind_w), .taken_o(tk_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_type_o  <= 3'd0;
      is_branch_o <= 1'b0;
      taken_o     <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      out_type_o  <= kind_w;
      is_branch_o <= (kind_w != BT_NONE);
      taken_o     <= tk_w;
    end
  end
endmodule

// File: rtl/brc_classify_chk.sv
module brc_classify_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic       in_taken_i,
  input logic       out_valid_o,
  input logic [2:0] out_type_o,
  input logic       is_branch_o,
  input logic       taken_o
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) seen <= 1'b0; else seen <= 1'b1;

  p_valid_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> (out_valid_o == $past(in_valid_i)));

  p_isbr_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_branch_o == (out_type_o != 3'd0));

  p_none_untaken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_type_o == 3'd0) |-> !taken_o);

  p_forced_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_type_o inside {3'd1, 3'd2, 3'd4, 3'd5, 3'd6}) |-> taken_o);

  p_cond_copy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && (out_type_o == 3'd3 || out_type_o == 3'd7)) |-> (taken_o == $past(in_taken_i)));
endmodule

bind brc_classify_top brc_classify_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_taken_i(in_taken_i),
  .out_valid_o(out_valid_o), .out_type_o(out_type_o), .is_branch_o(is_branch_o), .taken_o(taken_o)
);

// File: tb/brc_classify_top_bench.sv
module brc_classify_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 2, NS = 4;
  localparam logic [7:0] SP = 8'd6, FL = 8'd25, IP = 8'd26;

  logic clk = 0, rst_n = 0;
  logic vld = 0, tkn = 0;
  logic [ND*8-1:0] dst = '0;
  logic [NS*8-1:0] src = '0;
  logic ov, ib, ot;
  logic [2:0] oty;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brc_classify_top u_brc_classify_top (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(vld), .in_dst_i(dst), .in_src_i(src),
    .in_taken_i(tkn), .out_valid_o(ov), .out_type_o(oty), .is_branch_o(ib), .taken_o(ot));

  function automatic void model(input logic [ND*8-1:0] d, input logic [NS*8-1:0] s,
                                input logic t, output int ty, output int tk);
    bit wsp = 0, wip = 0, rsp = 0, rfl = 0, rip = 0, rot = 0;
    for (int k = 0; k < ND; k++) begin
      if (d[k*8 +: 8] == SP) wsp = 1;
      if (d[k*8 +: 8] == IP) wip = 1;
    end
    for (int k = 0; k < NS; k++) begin
      logic [7:0] r = s[k*8 +: 8];
      if (r == SP) rsp = 1;
      else if (r == FL) rfl = 1;
      else if (r == IP) rip = 1;
      else if (r != 0) rot = 1;
    end
    if (!rsp && !rfl && wip && !rot) ty = 1;
    else if (!rsp && !rip && !rfl && wip && rot) ty = 2;
    else if (!rsp && rip && !wsp && wip && (rfl || rot)) ty = 3;
    else if (rsp && rip && wsp && wip && !rfl && !rot) ty = 4;
    else if (rsp && rip && wsp && wip && !rfl && rot) ty = 5;
    else if (rsp && !rip && wsp && wip) ty = 6;
    else if (wip) ty = 7;
    else ty = 0;
    tk = (ty == 0) ? 0 : (ty == 3 || ty == 7) ? int'(t) : 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // apply at negedge, sample after following posedge
  task automatic drive(input logic [ND*8-1:0] d, input logic [NS*8-1:0] s,
                       input logic t, input logic v, input string req);
    int ety, etk;
    @(negedge clk);
    dst = d; src = s; tkn = t; vld = v;
    model(d, s, t, ety, etk);
    @(negedge clk);
    chk({req, " R9 valid"}, int'(ov), int'(v));
    chk({req, " R2 type"}, int'(oty), ety);
    chk({req, " R8 taken"}, int'(ot), etk);
    chk({req, " R8 is_branch"}, int'(ib), int'(ety != 0));
  endtask

  function automatic logic [7:0] pick(input int r);
    case (r % 8)
      0, 1: return 8'd0;
      2: return SP;
      3: return FL;
      4: return IP;
      default: return 8'(1 + (r % 5));
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD*20000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk("R9 reset valid", int'(ov), 0);
    rst_n = 1;
    drive('0, '0, 1, 1, "R1 all zero");
    drive({8'd0, IP}, '0, 0, 1, "R3 direct jump");
    drive({8'd0, IP}, {24'd0, 8'd9}, 0, 1, "R3 indirect jump");
    drive({8'd0, IP}, {16'd0, IP, FL}, 1, 1, "R4 cond taken");
    drive({8'd0, IP}, {16'd0, 8'd3, IP}, 0, 1, "R4 cond not taken");
    drive({SP, IP}, {16'd0, IP, SP}, 0, 1, "R5 direct call");
    drive({SP, IP}, {8'd0, 8'd7, IP, SP}, 0, 1, "R5 indirect call");
    drive({IP, SP}, {24'd0, SP}, 0, 1, "R6 return");
    drive({8'd0, IP}, {8'd0, SP, FL, IP}, 1, 1, "R7 other ip+fl+sp");
    drive({8'd0, IP}, {8'd0, SP, FL, IP}, 0, 1, "R7 other not taken");
    drive({8'd0, 8'd5}, {SP, FL, IP, 8'd4}, 1, 1, "R7 no ip write");
    drive({8'd0, IP}, {8'd0, 8'd0, 8'd0, 8'd0}, 0, 0, "R9 invalid");
    drive({8'd0, IP}, {8'd0, FL, 8'd0, 8'd0}, 0, 1, "R10 flags only read");
    for (int i = 0; i < 3000; i++) begin
      logic [ND*8-1:0] d;
      logic [NS*8-1:0] s;
      for (int k = 0; k < ND; k++) d[k*8 +: 8] = pick($urandom);
      for (int k = 0; k < NS; k++) s[k*8 +: 8] = pick($urandom);
      if ($urandom % 3 != 0) d[0 +: 8] = IP;
      drive(d, s, 1'($urandom), 1'($urandom), "R2 random");
    end
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R9 reset clears valid", int'(ov), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule